// File: doc/BRIEF.md
# Serial volume control receiver

This block sits between a two-wire serial control port, driven by a host microcontroller, and a six-channel analog attenuator bank. The host sends 16-bit control words, one bit per serial clock pulse. The block samples the asynchronous serial clock and data pins with a fast system clock. When the host signals the end of a word, the block stores two 7-bit attenuation codes into one pair of channel registers.

The channels form three pairs: front left/right, centre/subwoofer and surround left/right. Two trailing select bits in each word name the pair to write. A fourth select value is a test code that writes no channel. Each stored code is decoded into an attenuation figure in dB and a mute flag for the analog side. A per-pair strobe tells the analog side when a pair has just been rewritten.

A word is committed only by a latch event. The host makes one by holding the data pin high through a falling edge of the serial clock. Words of the wrong length are thrown away.

Top module: `vol_serial_rx`

## Requirements
- R1: A synchronous active-low reset sets every channel register to the mute code 7'b1100000, so all six `mute_o` bits read 1 and every `atten_o` field reads 127. It also clears `upd_o`.
- R2: The data pin is sampled at each rising serial clock edge, and the first bit sent is bit 0 of the word. Bits 0–6 are the first channel's code, LSB first. Bits 7–13 are the second channel's code.
- R3: A committed word with bit 14 = 0 and bit 15 = 0 writes channel 0 (front left) with the first code and channel 1 (front right) with the second code. No other channel changes.
- R4: A committed word with bit 14 = 1 and bit 15 = 0 writes channel 2 (centre) and channel 3 (subwoofer). No other channel changes.
- R5: A committed word with bit 14 = 0 and bit 15 = 1 writes channel 4 (surround left) and channel 5 (surround right). No other channel changes.
- R6: A committed word with bit 14 = 1 and bit 15 = 1 is accepted but changes no channel register and raises no strobe.
- R7: A latch event (data high at a falling serial clock edge) commits the word only when exactly 16 rising edges were counted since the previous latch event. Otherwise the word is discarded. The bit counter is cleared by every latch event.
- R8: A code from 0 to 95 gives `atten_o` = code and `mute_o` = 0. A code whose two top bits are both 1 (96–127) gives `mute_o` = 1 and `atten_o` = 127.
- R9: Each write to a pair raises that pair's bit of `upd_o` (bit 0 = channels 0/1, bit 1 = channels 2/3, bit 2 = channels 4/5) for exactly one system clock cycle. This happens in the same cycle that the new values appear. At most one bit is high at a time.
- R10: A falling serial clock edge with the data pin low is not a latch event, and no channel changes.
- R11: Serial pin activity while reset is asserted has no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each serial pin level must last at least 4 cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Asynchronous serial clock pin |
| ser_dat_i | input | 1 | Asynchronous serial data pin |
| atten_o | output | NUM_PAIRS*2*CODE_W (42) | Per-channel attenuation in dB, channel n at bits [7n+6:7n]; 127 when muted |
| mute_o | output | NUM_PAIRS*2 (6) | Per-channel mute flag |
| upd_o | output | NUM_PAIRS (3) | One-cycle strobe per pair on each write |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that the strobe is one-hot and lasts one cycle;
- that channel outputs move only in a strobe cycle;
- that a commit follows exactly sixteen counted bits;
- that a test-code commit raises no strobe, and any other commit strobes its own pair;
- that an unmuted channel never reports more than 95 dB.

Only the bench's scenarios show the rest:
- the bit order and field placement of each word;
- which pair each select value reaches;
- that short and long words leave all channels unchanged;
- that a data-low falling edge does nothing;
- that traffic during reset is ignored.

// File: rtl/vol_rx_pkg.sv
// Shared constants and types for the serial volume control receiver.
// Assumes 7-bit channel codes and 16-bit control words.
package vol_rx_pkg;
    localparam int CODE_W     = 7;
    localparam int FRAME_BITS = 2 * CODE_W + 2;

    // Value of the two select bits {bit15, bit14}
    typedef enum logic [1:0] {
        SEL_FRONT  = 2'b00,
        SEL_CENTRE = 2'b01,
        SEL_SURR   = 2'b10,
        SEL_TEST   = 2'b11
    } pair_sel_e;

    // One received control word, bit 0 is the first bit on the wire
    typedef struct packed {
        pair_sel_e          sel;
        logic [CODE_W-1:0]  code_b;
        logic [CODE_W-1:0]  code_a;
    } frame_t;

    localparam logic [CODE_W-1:0] MUTE_CODE = {2'b11, {(CODE_W-2){1'b0}}};
endpackage

// File: rtl/vol_rx_sync.sv
// Synchroniser and edge detector for asynchronous pins.
// Each pin passes through STAGES flops. A further flop holds the previous
// synchronised level, so rise and fall pulses last one cycle.
// Assumes each pin level is held for more than STAGES+1 system clock cycles.
module vol_rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Move the pin level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign rise_o[g]  = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[g]  = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/vol_rx_shift.sv
// Word assembler: shifts in data at each rising serial clock edge, LSB first,
// and counts the bits. A falling serial clock edge with data high is a latch
// event. It commits the word only after exactly FRAME_BITS bits, and it
// always clears the counter. Assumes rise and fall never coincide.
module vol_rx_shift
    import vol_rx_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    parameter int CNT_W = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise_i,
    input  logic             sclk_fall_i,
    input  logic             sdat_i,
    output logic [NBITS-1:0] frame_o,
    output logic             commit_o,
    output logic [CNT_W-1:0] bit_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [NBITS-1:0] shreg_q;
    logic [NBITS-1:0] frame_q;
    logic [CNT_W-1:0] cnt_q;
    logic             commit_q;
    logic             latch_ev;

    assign latch_ev = sclk_fall_i & sdat_i;

    // Shift register: newest bit enters at the top and walks toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (sclk_rise_i) begin
            shreg_q <= {sdat_i, shreg_q[NBITS-1:1]};
        end
    end

    // Bit counter: saturating count of rising edges, cleared by a latch event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (latch_ev) begin
            cnt_q <= '0;
        end else if (sclk_rise_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Commit: capture a full word and pulse the commit flag for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            frame_q  <= '0;
        end else begin
            commit_q <= latch_ev && (cnt_q == CNT_FULL);
            if (latch_ev && (cnt_q == CNT_FULL)) begin
                frame_q <= shreg_q;
            end
        end
    end

    assign frame_o   = frame_q;
    assign commit_o  = commit_q;
    assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/vol_rx_bank.sv
// Channel register bank: NUM_PAIRS pairs of code registers. A committed word
// whose select value equals a pair index writes both codes of that pair and
// raises that pair's update strobe for one cycle. Select values of
// NUM_PAIRS or more write nothing. Assumes NUM_PAIRS <= 4.
module vol_rx_bank
    import vol_rx_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int NUM_CH    = 2 * NUM_PAIRS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_i,
    input  frame_t                   frame_i,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic [NUM_PAIRS-1:0]     upd_o
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [CODE_W-1:0] first_q;
        logic [CODE_W-1:0] second_q;
        logic              upd_q;
        logic              wr;

        assign wr = commit_i && (frame_i.sel == 2'(p));

        // Pair registers: load both codes when this pair is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                first_q  <= MUTE_CODE;
                second_q <= MUTE_CODE;
                upd_q    <= 1'b0;
            end else begin
                upd_q <= wr;
                if (wr) begin
                    first_q  <= frame_i.code_a;
                    second_q <= frame_i.code_b;
                end
            end
        end

        assign codes_o[(2*p)*CODE_W   +: CODE_W] = first_q;
        assign codes_o[(2*p+1)*CODE_W +: CODE_W] = second_q;
        assign upd_o[p] = upd_q;
    end
endmodule

// File: rtl/vol_rx_decode.sv
// Code decoder: a code whose two top bits are both set means mute, and it is
// reported as an all-ones attenuation. Any other code is the attenuation in
// dB. Purely combinational, one instance per channel by generate.
module vol_rx_decode
    import vol_rx_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH*CODE_W-1:0] codes_i,
    output logic [NUM_CH*CODE_W-1:0] atten_o,
    output logic [NUM_CH-1:0]        mute_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CODE_W-1:0] code;
        logic              mute;

        assign code = codes_i[c*CODE_W +: CODE_W];

        // Map one code to its mute flag and dB figure
        always_comb begin
            mute = &code[CODE_W-1:CODE_W-2];
            atten_o[c*CODE_W +: CODE_W] = mute ? {CODE_W{1'b1}} : code;
        end

        assign mute_o[c] = mute;
    end
endmodule

// File: rtl/vol_serial_rx.sv
// Serial volume control receiver top: synchroniser, word assembler,
// pair-select register bank and per-channel decoder.
// Assumes the system clock gives each serial pin level at least 4 cycles.
module vol_serial_rx
    import vol_rx_pkg::*;
#(
    parameter int NUM_PAIRS   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CH      = 2 * NUM_PAIRS,
    parameter int CNT_W       = $clog2(FRAME_BITS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk_i,
    input  logic                     ser_dat_i,
    output logic [NUM_CH*CODE_W-1:0] atten_o,
    output logic [NUM_CH-1:0]        mute_o,
    output logic [NUM_PAIRS-1:0]     upd_o
);
    logic [1:0]              lvl_w;
    logic [1:0]              rise_w;
    logic [1:0]              fall_w;
    logic [FRAME_BITS-1:0]   frame_w;
    logic                    commit_w;
    logic [CNT_W-1:0]        bit_cnt_w;
    logic [NUM_CH*CODE_W-1:0] codes_w;
    frame_t                  frame_s;

    vol_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({ser_dat_i, ser_clk_i}),
        .level_o (lvl_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    vol_rx_shift #(.NBITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (rise_w[0]),
        .sclk_fall_i (fall_w[0]),
        .sdat_i      (lvl_w[1]),
        .frame_o     (frame_w),
        .commit_o    (commit_w),
        .bit_cnt_o   (bit_cnt_w)
    );

    assign frame_s = frame_t'(frame_w);

    vol_rx_bank #(.NUM_PAIRS(NUM_PAIRS), .NUM_CH(NUM_CH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_w),
        .frame_i  (frame_s),
        .codes_o  (codes_w),
        .upd_o    (upd_o)
    );

    vol_rx_decode #(.NUM_CH(NUM_CH)) u_dec (
        .codes_i (codes_w),
        .atten_o (atten_o),
        .mute_o  (mute_o)
    );

    // Data-pin edges are not used; only its level matters
    logic unused_dat_edges;
    assign unused_dat_edges = rise_w[1] ^ fall_w[1];
endmodule

// File: rtl/vol_serial_rx_chk.sv
// Checker for vol_serial_rx, attached by bind below. It watches the ports and
// the commit, select and bit-count signals between the assembler and the bank.
module vol_serial_rx_chk
    import vol_rx_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int NUM_CH    = 2 * NUM_PAIRS,
    parameter int CNT_W     = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*CODE_W-1:0] atten_o,
    input logic [NUM_CH-1:0]        mute_o,
    input logic [NUM_PAIRS-1:0]     upd_o,
    input logic                     commit,
    input logic [1:0]               sel,
    input logic [CNT_W-1:0]         bit_cnt
);
    localparam int MAX_DB = 3 * (1 << (CODE_W - 2)) - 1;

    AST_RESET_MUTE: assert property (@(posedge clk)
        !rst_n |=> ((&mute_o) && (upd_o == '0))); // R1

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o)); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_o) |=> (upd_o == '0)); // R9

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o == '0) |-> ($stable(atten_o) && $stable(mute_o))); // R10

    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS))); // R7

    AST_TEST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (sel == 2'b11)) |=> (upd_o == '0)); // R6

    AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (int'(sel) < NUM_PAIRS)) |=>
            (upd_o == (NUM_PAIRS'(1) << $past(sel)))); // R3

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rng
        AST_ATTEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            !mute_o[c] |-> (int'(atten_o[c*CODE_W +: CODE_W]) <= MAX_DB)); // R8
        AST_MUTE_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
            mute_o[c] |-> (&atten_o[c*CODE_W +: CODE_W])); // R8
    end
endmodule

bind vol_serial_rx vol_serial_rx_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .NUM_CH    (NUM_CH),
    .CNT_W     (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .atten_o (atten_o),
    .mute_o  (mute_o),
    .upd_o   (upd_o),
    .commit  (commit_w),
    .sel     (frame_w[FRAME_BITS-1:FRAME_BITS-2]),
    .bit_cnt (bit_cnt_w)
);

// File: tb/vol_serial_rx_test.sv
module vol_serial_rx_test;
    localparam int NP   = 3;
    localparam int NC   = 6;
    localparam int CW   = 7;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [NC*CW-1:0] atten;
    logic [NC-1:0]    mute;
    logic [NP-1:0]    upd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int model [NC];
    int exp_upd [NP];
    int seen_upd [NP];

    always #2 clk = ~clk;

    vol_serial_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .atten_o   (atten),
        .mute_o    (mute),
        .upd_o     (upd)
    );

    // Count strobe pulses away from the active edge
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) if (upd[p]) seen_upd[p]++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NC; c++) begin
            int  ea = (model[c] >= 96) ? 127 : model[c];
            int  em = (model[c] >= 96) ? 1 : 0;
            int  aa = int'(atten[c*CW +: CW]);
            chk(aa == ea, req, $sformatf("ch%0d atten", c), aa, ea);
            chk(int'(mute[c]) == em, req, $sformatf("ch%0d mute", c), int'(mute[c]), em);
        end
        for (int p = 0; p < NP; p++)
            chk(seen_upd[p] == exp_upd[p], req, $sformatf("pair%0d strobes", p),
                seen_upd[p], exp_upd[p]);
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) model[c] = 96;
    endtask

    task automatic model_write(input int a, input int b, input int sel);
        if (sel < NP) begin
            model[2*sel]   = a;
            model[2*sel+1] = b;
            exp_upd[sel]++;
        end
    endtask

    // Send nbits bits of w (bits past 15 are zero), optionally ending in a latch
    task automatic send_bits(input logic [15:0] w, input int nbits, input bit latch);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) ser_dat = (i < 16) ? w[i] : 1'b0;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_dat = (latch && i == nbits - 1);
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            ser_dat = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [15:0] word(input int a, input int b, input int sel);
        return {sel[1], sel[0], b[6:0], a[6:0]};
    endfunction

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_front();
        send_bits(word(5, 90, 0), 16, 1'b1);
        model_write(5, 90, 0);
        check_all("R3");
        send_bits(word(1, 64, 0), 16, 1'b1);
        model_write(1, 64, 0);
        check_all("R2");
    endtask

    task automatic t_centre();
        send_bits(word(0, 33, 1), 16, 1'b1);
        model_write(0, 33, 1);
        check_all("R4");
    endtask

    task automatic t_surround();
        send_bits(word(37, 100, 2), 16, 1'b1);
        model_write(37, 100, 2);
        check_all("R5");
    endtask

    task automatic t_test_code();
        send_bits(word(3, 3, 3), 16, 1'b1);
        check_all("R6");
    endtask

    task automatic t_bad_length();
        send_bits(word(10, 11, 0), 15, 1'b1);
        check_all("R7");
        send_bits(word(12, 13, 1), 17, 1'b1);
        check_all("R7");
        send_bits(word(20, 21, 1), 16, 1'b1);
        model_write(20, 21, 1);
        check_all("R7");
    endtask

    task automatic t_no_latch();
        send_bits(word(44, 45, 2), 16, 1'b0);
        check_all("R10");
        send_bits(16'h0000, 1, 1'b1);
        check_all("R10");
        send_bits(word(46, 47, 2), 16, 1'b1);
        model_write(46, 47, 2);
        check_all("R10");
    endtask

    task automatic t_code_edges();
        send_bits(word(95, 96, 0), 16, 1'b1);
        model_write(95, 96, 0);
        check_all("R8");
        send_bits(word(127, 0, 1), 16, 1'b1);
        model_write(127, 0, 1);
        check_all("R8");
    endtask

    task automatic t_reset_ignore();
        @(negedge clk) rst_n = 1'b0;
        send_bits(word(7, 8, 0), 16, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        model_reset();
        check_all("R11");
        send_bits(word(9, 19, 2), 16, 1'b1);
        model_write(9, 19, 2);
        check_all("R11");
    endtask

    initial begin
        model_reset();
        for (int p = 0; p < NP; p++) begin
            exp_upd[p]  = 0;
            seen_upd[p] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_front();
        t_centre();
        t_surround();
        t_test_code();
        t_bad_length();
        t_no_latch();
        t_code_edges();
        t_reset_ignore();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule